// File: doc/BRIEF.md
# Compare Output Waveform Generator

This block is the output stage that sits between a timer's counter and two output pins. Each cycle it takes the events the counter reports (a compare match on either channel, the counter reaching BOTTOM, the current count direction and whether a channel's compare value equals TOP) and turns them into a registered waveform level per channel. What each event does depends on a 2-bit output code per channel and on the class of the 4-bit timer mode: plain counting or clear-on-match, single-slope fast PWM, or dual-slope PWM.

Alongside each waveform level the block produces a pin override flag, which says that the waveform rather than ordinary port logic owns the pin. It also produces an output enable, which is the override qualified by that pin's direction bit. Only channel A has a toggle function in the PWM classes, and only in a few modes. A compare value equal to TOP changes how the PWM classes treat a match.

Top module: `cmpout_wavegen`

## Requirements
- R1: While `rst_n` is low, both waveform registers are 0. With both codes at 00, both override and both enable outputs are 0 after reset.
- R2: With output code 00 a channel is disconnected. Its override and enable are 0 and its waveform register keeps its value whatever events arrive.
- R3: A channel that is connected (R4 to R11 decide this) drives its override to 1 in the same cycle. Its enable equals override AND its direction bit. Both are combinational from the inputs.
- R4: In plain modes 0, 4 and 12 every nonzero code connects the channel. On a match, code 01 inverts the waveform, 10 drives it to 0 and 11 drives it to 1, taking effect at the clock edge that samples the match.
- R5: In fast modes 5, 6, 7, 14 and 15, code 10 drives 0 on a match and 1 at BOTTOM. Code 11 drives 1 on a match and 0 at BOTTOM. When a match and BOTTOM come in the same cycle, the match decides.
- R6: In fast modes, code 01 connects channel A and inverts it on a match only in modes 14 and 15. In the other fast modes code 01 leaves channel A disconnected, and it always leaves channel B disconnected.
- R7: In dual-slope modes 1, 2, 3, 8, 9, 10 and 11, code 10 drives 0 on a match while counting up (`count_down`=0) and 1 on a match while counting down. Code 11 does the reverse.
- R8: In dual-slope modes, code 01 connects channel A and inverts it on a match only in modes 9 and 11. In the other dual-slope modes code 01 leaves channel A disconnected, and it always leaves channel B disconnected.
- R9: In fast modes with code 10 or 11, a match flagged with the channel's equals-TOP bit is ignored, while the BOTTOM action still applies.
- R10: In dual-slope modes with code 10 or 11, while the equals-TOP bit is set the waveform is driven every cycle to its up-count match level: 0 for code 10, 1 for code 11.
- R11: Mode 13 is reserved. Both channels are disconnected and hold their waveform.
- R12: When a connected channel sees no match and no BOTTOM (and R10 does not apply), its waveform keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_mode | input | 4 | Timer mode number |
| code_a | input | 2 | Output code, channel A |
| code_b | input | 2 | Output code, channel B |
| hit_a | input | 1 | Compare match strobe, channel A |
| hit_b | input | 1 | Compare match strobe, channel B |
| at_bottom | input | 1 | Counter is at BOTTOM this cycle |
| count_down | input | 1 | Counter is counting down |
| a_eq_top | input | 1 | Channel A compare value equals TOP |
| b_eq_top | input | 1 | Channel B compare value equals TOP |
| dir_a | input | 1 | Direction bit of pin A |
| dir_b | input | 1 | Direction bit of pin B |
| wave_a | output | 1 | Waveform level, channel A |
| wave_b | output | 1 | Waveform level, channel B |
| ovr_a | output | 1 | Waveform owns pin A |
| ovr_b | output | 1 | Waveform owns pin B |
| oe_a | output | 1 | Drive enable, pin A |
| oe_b | output | 1 | Drive enable, pin B |

## Verification
The bench covers every combination of the sixteen mode numbers, both channels' codes, and the six event inputs: both matches, BOTTOM, direction and both equals-TOP bits. The waveform state carried from one step to the next also brings each rule in with both starting levels. Including the equals-TOP bits separates the suppressed-match and forced-level cases from ordinary matches. Stepping the mode through every value separates the toggle-capable modes 9, 11, 14 and 15 from the neighbouring modes of the same class, and the reserved mode from all the others. Driving the direction bits independently of the codes separates override from enable.

// File: rtl/cmpout_pkg.sv
`timescale 1ns/1ps
package cmpout_pkg;
   typedef enum logic [1:0] {
      CLS_PLAIN = 2'd0,
      CLS_FAST  = 2'd1,
      CLS_DUAL  = 2'd2,
      CLS_VOID  = 2'd3
   } mode_cls_t;

   localparam logic [1:0] CODE_OFF = 2'b00;
   localparam logic [1:0] CODE_TGL = 2'b01;
   localparam logic [1:0] CODE_LO  = 2'b10;
   localparam logic [1:0] CODE_HI  = 2'b11;
endpackage

// File: rtl/cmpout_mode_decode.sv
`timescale 1ns/1ps
module cmpout_mode_decode
   import cmpout_pkg::*;
#(
   parameter int MODE_W = 4,
   parameter logic [(1<<MODE_W)-1:0] PLAIN_SET = 16'h1011,
   parameter logic [(1<<MODE_W)-1:0] FAST_SET  = 16'hC0E0,
   parameter logic [(1<<MODE_W)-1:0] DUAL_SET  = 16'h0F0E,
   parameter logic [(1<<MODE_W)-1:0] TGL_SET   = 16'hCA00
) (
   input  logic [MODE_W-1:0] mode,
   output mode_cls_t         cls,
   output logic              tgl_ok
);
   localparam int NMODES = 1 << MODE_W;

   if (MODE_W < 1 || MODE_W > 8) begin : g_bad_width
      $error("cmpout_mode_decode: MODE_W out of range");
   end
   if (((PLAIN_SET & FAST_SET) | (PLAIN_SET & DUAL_SET) | (FAST_SET & DUAL_SET)) != '0) begin : g_overlap
      $error("cmpout_mode_decode: mode classes overlap");
   end
   if ((TGL_SET & ~(FAST_SET | DUAL_SET)) != '0) begin : g_bad_tgl
      $error("cmpout_mode_decode: toggle modes must be PWM modes");
   end

   logic [NMODES-1:0] sel;
   assign sel = NMODES'(1) << mode;

   always_comb begin
      if ((sel & PLAIN_SET) != '0)     cls = CLS_PLAIN;
      else if ((sel & FAST_SET) != '0) cls = CLS_FAST;
      else if ((sel & DUAL_SET) != '0) cls = CLS_DUAL;
      else                             cls = CLS_VOID;
   end

   assign tgl_ok = (sel & TGL_SET) != '0;
endmodule

// File: rtl/cmpout_channel.sv
`timescale 1ns/1ps
module cmpout_channel
   import cmpout_pkg::*;
#(
   parameter bit   HAS_TGL  = 1'b1,
   parameter logic WAVE_RST = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  mode_cls_t cls,
   input  logic      tgl_ok,
   input  logic [1:0] code,
   input  logic      hit,
   input  logic      bottom,
   input  logic      down,
   input  logic      eq_top,
   input  logic      dir,
   output logic      wave,
   output logic      ovr,
   output logic      oe
);
   localparam logic TGL_GATE = HAS_TGL;

   logic wave_q, wave_d, active, tgl_en;

   assign tgl_en = tgl_ok & TGL_GATE;

   always_comb begin
      active = 1'b0;
      wave_d = wave_q;
      unique case (cls)
         CLS_PLAIN: begin
            active = (code != CODE_OFF);
            if (hit) begin
               case (code)
                  CODE_TGL: wave_d = ~wave_q;
                  CODE_LO:  wave_d = 1'b0;
                  CODE_HI:  wave_d = 1'b1;
                  default:  wave_d = wave_q;
               endcase
            end
         end
         CLS_FAST: begin
            if (code[1]) begin
               active = 1'b1;
               if (hit && !eq_top) wave_d = code[0];
               else if (bottom)    wave_d = ~code[0];
            end else if (code[0] && tgl_en) begin
               active = 1'b1;
               if (hit) wave_d = ~wave_q;
            end
         end
         CLS_DUAL: begin
            if (code[1]) begin
               active = 1'b1;
               if (eq_top)   wave_d = code[0];
               else if (hit) wave_d = code[0] ^ down;
            end else if (code[0] && tgl_en) begin
               active = 1'b1;
               if (hit) wave_d = ~wave_q;
            end
         end
         default: active = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) wave_q <= WAVE_RST;
      else        wave_q <= wave_d;
   end

   assign wave = wave_q;
   assign ovr  = active;
   assign oe   = active & dir;

   assert_reset_value_R1: assert property (@(posedge clk)
      !rst_n |=> (wave_q == WAVE_RST));

   assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr |=> $stable(wave_q));

   assert_plain_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == CLS_PLAIN && code == CODE_HI && hit) |=> wave_q);

   assert_fast_top_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == CLS_FAST && code[1] && eq_top && !bottom) |=> $stable(wave_q));

   assert_dual_top_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == CLS_DUAL && code[1] && eq_top) |=> (wave_q == $past(code[0])));
endmodule

// File: rtl/cmpout_wavegen.sv
`timescale 1ns/1ps
module cmpout_wavegen
   import cmpout_pkg::*;
#(
   parameter int MODE_W = 4,
   parameter logic [(1<<MODE_W)-1:0] PLAIN_SET = 16'h1011,
   parameter logic [(1<<MODE_W)-1:0] FAST_SET  = 16'hC0E0,
   parameter logic [(1<<MODE_W)-1:0] DUAL_SET  = 16'h0F0E,
   parameter logic [(1<<MODE_W)-1:0] TGL_SET   = 16'hCA00,
   parameter logic WAVE_RST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] tmr_mode,
   input  logic [1:0]        code_a,
   input  logic [1:0]        code_b,
   input  logic              hit_a,
   input  logic              hit_b,
   input  logic              at_bottom,
   input  logic              count_down,
   input  logic              a_eq_top,
   input  logic              b_eq_top,
   input  logic              dir_a,
   input  logic              dir_b,
   output logic              wave_a,
   output logic              wave_b,
   output logic              ovr_a,
   output logic              ovr_b,
   output logic              oe_a,
   output logic              oe_b
);
   localparam int NCH = 2;

   mode_cls_t cls;
   logic      tgl_ok;

   cmpout_mode_decode #(
      .MODE_W(MODE_W), .PLAIN_SET(PLAIN_SET), .FAST_SET(FAST_SET),
      .DUAL_SET(DUAL_SET), .TGL_SET(TGL_SET)
   ) u_dec (
      .mode(tmr_mode), .cls(cls), .tgl_ok(tgl_ok)
   );

   logic [1:0]     ch_code [NCH];
   logic [NCH-1:0] ch_hit, ch_top, ch_dir, ch_wave, ch_ovr, ch_oe;

   assign ch_code[0] = code_a;
   assign ch_code[1] = code_b;
   assign ch_hit = {hit_b, hit_a};
   assign ch_top = {b_eq_top, a_eq_top};
   assign ch_dir = {dir_b, dir_a};

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      cmpout_channel #(.HAS_TGL(i == 0), .WAVE_RST(WAVE_RST)) u_ch (
         .clk(clk), .rst_n(rst_n), .cls(cls), .tgl_ok(tgl_ok),
         .code(ch_code[i]), .hit(ch_hit[i]), .bottom(at_bottom),
         .down(count_down), .eq_top(ch_top[i]), .dir(ch_dir[i]),
         .wave(ch_wave[i]), .ovr(ch_ovr[i]), .oe(ch_oe[i])
      );
   end

   assign wave_a = ch_wave[0];
   assign wave_b = ch_wave[1];
   assign ovr_a  = ch_ovr[0];
   assign ovr_b  = ch_ovr[1];
   assign oe_a   = ch_oe[0];
   assign oe_b   = ch_oe[1];

   assert_b_no_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (((FAST_SET | DUAL_SET) >> tmr_mode) & 1) != 0 && code_b == CODE_TGL |-> !ovr_b);

   assert_reserved_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (((PLAIN_SET | FAST_SET | DUAL_SET) >> tmr_mode) & 1) == 0 |-> !ovr_a && !ovr_b);
endmodule

// File: tb/sim_cmpout_wavegen.sv
`timescale 1ns/1ps
module sim_cmpout_wavegen;
   logic clk = 1'b0, rst_n = 1'b0;
   logic [3:0] tmr_mode = '0;
   logic [1:0] code_a = '0, code_b = '0;
   logic hit_a = 0, hit_b = 0, at_bottom = 0, count_down = 0;
   logic a_eq_top = 0, b_eq_top = 0, dir_a = 0, dir_b = 0;
   logic wave_a, wave_b, ovr_a, ovr_b, oe_a, oe_b;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   cmpout_wavegen u0 (
      .clk(clk), .rst_n(rst_n), .tmr_mode(tmr_mode), .code_a(code_a), .code_b(code_b),
      .hit_a(hit_a), .hit_b(hit_b), .at_bottom(at_bottom), .count_down(count_down),
      .a_eq_top(a_eq_top), .b_eq_top(b_eq_top), .dir_a(dir_a), .dir_b(dir_b),
      .wave_a(wave_a), .wave_b(wave_b), .ovr_a(ovr_a), .ovr_b(ovr_b), .oe_a(oe_a), .oe_b(oe_b)
   );

   task automatic check(input string req, input string what, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s mode=%0d ca=%b cb=%b got=%b exp=%b", req, what,
                  tmr_mode, code_a, code_b, got, exp);
      end
   endtask

   // 0 plain, 1 fast, 2 dual, 3 reserved
   function automatic int kind(input int m);
      case (m)
         0, 4, 12:          return 0;
         5, 6, 7, 14, 15:   return 1;
         1, 2, 3, 8, 9, 10, 11: return 2;
         default:           return 3;
      endcase
   endfunction

   function automatic bit connected(input int m, input bit is_a, input logic [1:0] c);
      int k = kind(m);
      if (c == 2'b00 || k == 3) return 0;
      if (k == 0 || c[1]) return 1;
      if (!is_a) return 0;
      return (m == 14 || m == 15 || m == 9 || m == 11);
   endfunction

   function automatic logic next_level(input int m, input bit is_a, input logic [1:0] c,
                                       input logic cur, input logic h, input logic b,
                                       input logic dn, input logic t);
      int k = kind(m);
      if (!connected(m, is_a, c)) return cur;
      if (c == 2'b01) return h ? !cur : cur;
      if (k == 0) return h ? (c == 2'b11) : cur;
      if (k == 1) begin
         if (h && !t) return (c == 2'b11);
         if (b)       return (c == 2'b10);
         return cur;
      end
      if (t) return (c == 2'b11);
      if (h) return dn ? (c == 2'b10) : (c == 2'b11);
      return cur;
   endfunction

   function automatic string tag(input int m, input bit is_a, input logic [1:0] c,
                                 input logic h, input logic b, input logic t);
      int k = kind(m);
      if (k == 3) return "R11";
      if (c == 2'b00) return "R2";
      if (k == 0) return h ? "R4" : "R12";
      if (c == 2'b01) return (k == 1) ? "R6" : "R8";
      if (k == 1) begin
         if (t && h) return "R9";
         return (h || b) ? "R5" : "R12";
      end
      if (t) return "R10";
      return h ? "R7" : "R12";
   endfunction

   initial begin
      logic ea, eb, na, nb;
      repeat (3) @(posedge clk);
      #5;
      check("R1", "wave_a", wave_a, 1'b0);
      check("R1", "wave_b", wave_b, 1'b0);
      check("R1", "ovr_a", ovr_a, 1'b0);
      check("R1", "oe_b", oe_b, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      ea = 1'b0; eb = 1'b0;
      for (int m = 0; m < 16; m++) begin
         for (int c = 0; c < 16; c++) begin
            for (int ev = 0; ev < 64; ev++) begin
               @(negedge clk);
               tmr_mode = 4'(m);
               code_a = c[1:0]; code_b = c[3:2];
               hit_a = ev[0]; hit_b = ev[1]; at_bottom = ev[2];
               count_down = ev[3]; a_eq_top = ev[4]; b_eq_top = ev[5];
               dir_a = ev[1] ^ c[0]; dir_b = ev[2] ^ c[3];
               #1;
               check("R3", "ovr_a", ovr_a, connected(m, 1, code_a));
               check("R3", "ovr_b", ovr_b, connected(m, 0, code_b));
               check("R3", "oe_a", oe_a, connected(m, 1, code_a) & dir_a);
               check("R3", "oe_b", oe_b, connected(m, 0, code_b) & dir_b);
               na = next_level(m, 1, code_a, ea, hit_a, at_bottom, count_down, a_eq_top);
               nb = next_level(m, 0, code_b, eb, hit_b, at_bottom, count_down, b_eq_top);
               @(posedge clk);
               #2;
               check(tag(m, 1, code_a, hit_a, at_bottom, a_eq_top), "wave_a", wave_a, na);
               check(tag(m, 0, code_b, hit_b, at_bottom, b_eq_top), "wave_b", wave_b, nb);
               ea = na; eb = nb;
            end
         end
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 190000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R12 run did not finish got=hung exp=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule